// File: doc/BRIEF.md
# Stereo Frame Transmitter

This block is the converter end of a two-channel audio serial link. A single master clock feeds two registered dividers. One produces a bit clock, and the other produces a word clock that marks the left and right halves of each frame. During every frame the block sends four fields on one data line, most significant bit first: the left sample, a left peak-level byte, the right sample and a right peak-level byte. A receiver shifts each bit in at the low end on the rising bit clock edge and latches the frame on the rising word clock edge.

New parallel words enter through a valid/ready handshake into a holding register. The shift register loads from that holding register only when a frame begins, so every frame carries one coherent set of values. If nothing new has arrived by that point, the last frame is sent again.

Top module: `stereo_frame_tx`

## Requirements
- R1: The bit clock repeats every BCLK_DIV master cycles and is high for BCLK_DIV/2 of them. With defaults this is divide-by-4.
- R2: The word clock repeats every BCLK_DIV*2*(SAMPLE_W+PEAK_W) master cycles, which is 256 with defaults. That is one frame of 2*(SAMPLE_W+PEAK_W) bit clocks. It is high for the first SAMPLE_W+PEAK_W rising bit clock edges of the frame, which form the left half, and low for the rest. It changes only on the master edge where the bit clock falls.
- R3: After a frame, a receiver that shifts in at bit 0 holds the following layout, from the top bit down. With defaults the positions are 63..40, 39..32, 31..8 and 7..0.
  - The left sample occupies the top SAMPLE_W bits.
  - The left peak byte occupies the next PEAK_W bits.
  - The right sample occupies the next SAMPLE_W bits.
  - The right peak byte occupies the lowest PEAK_W bits.
- R4: Serial data changes only on the master edge where the bit clock falls, so it is stable at every rising bit clock edge.
- R5: in_ready is high while the holding register is empty. A word is taken on a master edge where in_valid and in_ready are both high. in_ready then stays low until the next frame begins.
- R6: A word taken before a frame begins is sent in full in that frame. A word taken on the very edge that starts a frame is sent in the frame after it.
- R7: If no word is waiting when a frame begins, the previous frame's bits are sent again. After reset this is all zeros.
- R8: While reset is high, the block drives the bit clock, word clock and data low, empties the holding register and clears the repeated frame. The first frame then starts BCLK_DIV master cycles after the first edge with reset low, in its left half.
- R9: While in_ready is low, in_valid and the data inputs have no effect on any frame sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Parallel words are offered |
| in_ready | output | 1 | Holding register is empty |
| in_left_smp | input | SAMPLE_W | Left sample |
| in_left_pk | input | PEAK_W | Left peak level |
| in_right_smp | input | SAMPLE_W | Right sample |
| in_right_pk | input | PEAK_W | Right peak level |
| bclk_o | output | 1 | Bit clock, registered divider output |
| wclk_o | output | 1 | Word clock, high in the left half |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with SAMPLE_W=4, PEAK_W=2 and BCLK_DIV=4. A frame is then 12 bits and 48 master cycles long, so every combination of the two 4-bit samples can be sent as its own frame in a short run. Each frame is rebuilt arithmetically by a receiver model in the bench and compared with what it latched. The small frame also makes the rarer orderings frequent. These include an offer made on the edge that starts a frame, runs of repeated frames, offers made while the holding register is full, and a reset in the middle of traffic.

// File: rtl/stx_pkg.sv
package stx_pkg;

  // Which half of a frame a bit belongs to; the word clock level follows it.
  typedef enum logic {
    HALF_RIGHT = 1'b0,
    HALF_LEFT  = 1'b1
  } stx_half_e;

  // Advance a bit index within a frame, wrapping at the frame length.
  function automatic int unsigned step_index(int unsigned idx, int unsigned frame_bits);
    return (idx + 1 >= frame_bits) ? 0 : idx + 1;
  endfunction

  // Half of the frame that bit index idx belongs to.
  function automatic stx_half_e half_of(int unsigned idx, int unsigned half_bits);
    return (idx < half_bits) ? HALF_LEFT : HALF_RIGHT;
  endfunction

  // Master-cycle count at which the bit clock goes high.
  function automatic int unsigned div_rise_point(int unsigned div);
    return div / 2 - 1;
  endfunction

endpackage

// File: rtl/stx_clkgen.sv
module stx_clkgen
  import stx_pkg::*;
#(
  parameter int unsigned BCLK_DIV   = 4,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic wclk_o,
  output logic bit_fall_o,
  output logic frame_start_o
);

  localparam int unsigned DW        = $clog2(BCLK_DIV);
  localparam int unsigned IW        = $clog2(FRAME_BITS);
  localparam int unsigned HALF_BITS = FRAME_BITS / 2;
  localparam logic [DW-1:0] DIV_LAST = DW'(BCLK_DIV - 1);
  localparam logic [DW-1:0] RISE_AT  = DW'(div_rise_point(BCLK_DIV));
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] IDX_HALF = IW'(HALF_BITS - 1);

  logic [DW-1:0] div_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nx;
  logic          bit_rise;
  logic          bclk_q;
  logic          wclk_q;

  // Internal events, brought out as named wires.
  assign bit_rise      = (div_q == RISE_AT);
  assign bit_fall_o    = (div_q == DIV_LAST);
  assign idx_nx        = IW'(step_index(32'(idx_q), FRAME_BITS));
  assign frame_start_o = bit_fall_o && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst)             div_q <= '0;
    else if (bit_fall_o) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  // The index rests on the last bit during reset, so the first fall starts bit 0.
  always_ff @(posedge clk) begin
    if (rst)             idx_q <= IDX_LAST;
    else if (bit_fall_o) idx_q <= idx_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      if (bit_rise)        bclk_q <= 1'b1;
      else if (bit_fall_o) bclk_q <= 1'b0;
      if (bit_fall_o)      wclk_q <= (half_of(32'(idx_nx), HALF_BITS) == HALF_LEFT);
    end
  end

  assign bclk_o = bclk_q;
  assign wclk_o = wclk_q;

  p_fall_from_high_r1: assert property (@(posedge clk) disable iff (rst)
    bit_fall_o |-> bclk_q);
  p_rise_from_low_r1: assert property (@(posedge clk) disable iff (rst)
    bit_rise |-> !bclk_q);
  p_wclk_with_bfall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(wclk_q) |-> $fell(bclk_q));
  p_left_at_start_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> wclk_q);
  p_right_after_half_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_fall_o && idx_q == IDX_HALF) |=> !wclk_q);

endmodule

// File: rtl/stx_holdreg.sv
module stx_holdreg #(
  parameter int unsigned FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               take_i,
  output logic               ready_o,
  output logic               full_o,
  output logic [FRAME_W-1:0] frame_o
);

  logic               full_q;
  logic [FRAME_W-1:0] data_q;
  logic               accept;

  assign accept = in_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst)          full_q <= 1'b0;
    else if (accept)  full_q <= 1'b1;
    else if (take_i)  full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         data_q <= '0;
    else if (accept) data_q <= in_frame;
  end

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign frame_o = data_q;

  p_ready_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ready_o) |=> !ready_o);
  p_release_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(full_q) |-> $past(take_i));
  p_ignore_when_full_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full_q) |=> $stable(data_q));

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int unsigned FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_i,
  input  logic               load_i,
  input  logic               fresh_i,
  input  logic [FRAME_W-1:0] fresh_frame_i,
  output logic               sdata_o
);

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] replay_q;
  logic [FRAME_W-1:0] src;
  logic               data_q;

  // Frame chosen at a boundary: the waiting one, or the last one again.
  assign src = fresh_i ? fresh_frame_i : replay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      replay_q <= '0;
      data_q   <= 1'b0;
    end else if (load_i) begin
      data_q   <= src[FRAME_W-1];
      sr_q     <= {src[FRAME_W-2:0], 1'b0};
      replay_q <= src;
    end else if (shift_i) begin
      data_q <= sr_q[FRAME_W-1];
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdata_o = data_q;

  p_replay_held_r7: assert property (@(posedge clk) disable iff (rst)
    (!load_i || !fresh_i) |=> $stable(replay_q));
  p_data_only_on_shift_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> $past(shift_i));

endmodule

// File: rtl/stereo_frame_tx.sv
module stereo_frame_tx #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned PEAK_W   = 8,
  parameter int unsigned BCLK_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left_smp,
  input  logic [PEAK_W-1:0]   in_left_pk,
  input  logic [SAMPLE_W-1:0] in_right_smp,
  input  logic [PEAK_W-1:0]   in_right_pk,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                sdata_o
);

  localparam int unsigned HALF_W  = SAMPLE_W + PEAK_W;
  localparam int unsigned FRAME_W = 2 * HALF_W;

  // Frame layout, top bit sent first: left sample, left peak, right sample, right peak.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [SAMPLE_W-1:0] ls, input logic [PEAK_W-1:0] lp,
    input logic [SAMPLE_W-1:0] rs, input logic [PEAK_W-1:0] rp);
    return {ls, lp, rs, rp};
  endfunction

  logic               bit_fall;
  logic               frame_start;
  logic               hold_full;
  logic [FRAME_W-1:0] in_frame;
  logic [FRAME_W-1:0] hold_frame;

  assign in_frame = pack_frame(in_left_smp, in_left_pk, in_right_smp, in_right_pk);

  stx_clkgen #(
    .BCLK_DIV  (BCLK_DIV),
    .FRAME_BITS(FRAME_W)
  ) u_clkgen (
    .clk          (clk),
    .rst          (rst),
    .bclk_o       (bclk_o),
    .wclk_o       (wclk_o),
    .bit_fall_o   (bit_fall),
    .frame_start_o(frame_start)
  );

  stx_holdreg #(
    .FRAME_W(FRAME_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_frame(in_frame),
    .take_i  (frame_start),
    .ready_o (in_ready),
    .full_o  (hold_full),
    .frame_o (hold_frame)
  );

  stx_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk          (clk),
    .rst          (rst),
    .shift_i      (bit_fall),
    .load_i       (frame_start),
    .fresh_i      (hold_full),
    .fresh_frame_i(hold_frame),
    .sdata_o      (sdata_o)
  );

  p_sdata_on_bfall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> $fell(bclk_o));
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!bclk_o && !wclk_o && !sdata_o && in_ready));

endmodule

// File: tb/test_stereo_frame_tx.sv
`timescale 1ns/1ps
module test_stereo_frame_tx;

  localparam int S    = 4;
  localparam int P    = 2;
  localparam int D    = 4;
  localparam int HALF = S + P;
  localparam int FB   = 2 * HALF;
  localparam int WPER = D * FB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [S-1:0] in_ls = '0, in_rs = '0;
  logic [P-1:0] in_lp = '0, in_rp = '0;
  logic in_ready, bclk, wclk, sdata;

  stereo_frame_tx #(.SAMPLE_W(S), .PEAK_W(P), .BCLK_DIV(D)) i_stereo_frame_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left_smp(in_ls), .in_left_pk(in_lp), .in_right_smp(in_rs), .in_right_pk(in_rp),
    .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sdata));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, rel_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected frame, built arithmetically from the field widths (R3).
  function automatic longint frame_val(int ls, int lp, int rs, int rp);
    return ((longint'(ls) * (1 << P) + lp) * (1 << HALF)) + rs * (1 << P) + rp;
  endfunction

  // Receiver model and expected-frame tracking
  bit prev_b, prev_w, prev_s, b_seen, w_seen, cur_fresh, pend_valid;
  int last_brise, last_w, bits_since_w, bits_left, pend_cyc;
  longint rx, exp_cur, pend;

  always @(negedge clk) begin
    if (rst) begin
      prev_b = 0; prev_w = 0; prev_s = 0; b_seen = 0; w_seen = 0;
      pend_valid = 0; exp_cur = 0; rx = 0; bits_since_w = 0; bits_left = 0;
    end else begin
      if (bclk && !prev_b) begin
        if (b_seen) chk(cyc - last_brise == D, "R1 bclk period", cyc - last_brise, D);
        b_seen = 1; last_brise = cyc;
        rx = ((rx << 1) | longint'(sdata)) & ((64'd1 << FB) - 1);
        bits_since_w++;
        if (wclk) bits_left++;
      end
      if (!bclk && prev_b)
        chk(cyc - last_brise == D / 2, "R1 bclk high time", cyc - last_brise, D / 2);
      if (sdata != prev_s)
        chk(prev_b && !bclk, "R4 data moved off a bclk fall", sdata, prev_s);
      if (wclk != prev_w)
        chk(prev_b && !bclk, "R2 wclk moved off a bclk fall", wclk, prev_w);
      if (wclk && !prev_w) begin
        if (!w_seen) chk(cyc == rel_cyc + D, "R8 first frame start", cyc - rel_cyc, D);
        else begin
          chk(cyc - last_w == WPER, "R2 wclk period", cyc - last_w, WPER);
          chk(bits_since_w == FB, "R2 bits per frame", bits_since_w, FB);
          chk(bits_left == HALF, "R2 left half length", bits_left, HALF);
          if (cur_fresh) chk(rx == exp_cur, "R3 R6 new frame content", rx, exp_cur);
          else           chk(rx == exp_cur, "R3 R7 repeated frame content", rx, exp_cur);
        end
        w_seen = 1; last_w = cyc; bits_since_w = 0; bits_left = 0;
        if (pend_valid && pend_cyc < cyc) begin
          exp_cur = pend; pend_valid = 0; cur_fresh = 1;
          chk(in_ready, "R5 ready back after frame start", in_ready, 1);
        end else cur_fresh = 0;
      end
      prev_b = bclk; prev_w = wclk; prev_s = sdata;
    end
  end

  task automatic push(input int ls, input int lp, input int rs, input int rp);
    do begin @(posedge clk); #1; end while (!(in_ready && !pend_valid));
    in_valid = 1; in_ls = S'(ls); in_lp = P'(lp); in_rs = S'(rs); in_rp = P'(rp);
    pend = frame_val(ls, lp, rs, rp); pend_cyc = cyc + 1; pend_valid = 1;
    @(posedge clk); #1;
    chk(!in_ready, "R5 ready low after accept", in_ready, 0);
    in_valid = 0;
  endtask

  // Offer junk while the holding register is full (R9).
  task automatic push_junk();
    do begin @(posedge clk); #1; end while (in_ready);
    in_valid = 1; in_ls = ~in_ls; in_lp = ~in_lp; in_rs = ~in_rs; in_rp = ~in_rp;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_frames(input int n);
    repeat (n * WPER) @(posedge clk);
    #1;
  endtask

  task automatic check_reset_state();
    chk(!bclk, "R8 bclk low in reset", bclk, 0);
    chk(!wclk, "R8 wclk low in reset", wclk, 0);
    chk(!sdata, "R8 data low in reset", sdata, 0);
    chk(in_ready, "R8 ready high in reset", in_ready, 1);
  endtask

  bit done = 0;

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check_reset_state();
    rst = 0; rel_cyc = cyc;
    wait_frames(3);
    for (int l = 0; l < 16; l++) begin
      for (int r = 0; r < 16; r++) begin
        push(l, l % 4, r, (l + r) % 4);
        if (((l + r) % 16) == 3) push_junk();
        if (r == 5) wait_frames(2);
      end
    end
    wait_frames(2);
    push(9, 1, 2, 3);
    @(posedge clk); #1;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    rst = 0; rel_cyc = cyc;
    wait_frames(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule